// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Generation

This block performs the eight shift and rotate operations of a legacy 16/32-bit processor core on an 8-, 16- or 32-bit operand. Each accepted request returns the shifted or rotated value. It also returns new values for the carry, overflow, sign, zero and parity flags, with a per-flag write-enable mask that tells the core which flags to commit.

The core presents an operation code, a size select, the operand, a raw shift count and its current carry flag, together with `in_valid`. One clock later the unit presents the result with `out_valid`. Only the low five bits of the count are used. A count of zero passes the operand through and asks for no flag write. Rotates through carry treat the carry flag as one extra bit of the ring.

Top module: `shrot_unit`

## Requirements
- R1: Operation codes: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 and 6 shift left, 5 logical shift right, 7 arithmetic shift right. Each request with `in_valid` high yields `out_valid` high with its result exactly one clock later, and `out_valid` is low otherwise.
- R2: Size codes: 0 selects 8 bits, 1 selects 16 bits, 2 and 3 select 32 bits. Operand bits above the selected size are ignored, and the matching result bits are zero.
- R3: Only count bits [4:0] are used, so a raw count of 40 acts as 8 and 32 acts as 0.
- R4: With a masked count of zero, the result is the size-masked operand, `flag_we` is all zero and every flag output is 0.
- R5: Rotates through carry act on a ring of size+1 bits made of CF above the operand. The effective count is the masked count modulo 9, 17 or 33.
- R6: For any nonzero count, `flag_we[0]` (CF) is set. CF is the last bit moved out of the operand; for plain rotates it is the bit that wrapped around.
- R7: With a count of 1, OF is the new CF XOR the result MSB for codes 0, 2, 4 and 6, and the XOR of the two top result bits for codes 1 and 3. `flag_we[4]` (OF) is set.
- R8: With a count of 1, OF is the original operand MSB for code 5 and 0 for code 7, and it is written.
- R9: For a masked count above 1, `flag_we[4]` is clear and `flag_of` is 0.
- R10: Arithmetic shift right fills every vacated bit with the original sign bit. For counts at or above the size, the result is all sign bits and CF equals the sign.
- R11: For codes 4 to 7 with a nonzero count, SF (`flag_we[3]`) is the result MSB and ZF (`flag_we[2]`) is set when the sized result is zero. PF (`flag_we[1]`) is 1 when the low 8 result bits hold an even number of ones. All three are written.
- R12: Codes 0 to 3 never set `flag_we[3:1]`, and SF, ZF and PF read 0 for them.
- R13: While `rst` is high, and until the first request after it, `out_valid`, `result`, every flag and `flag_we` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| size | input | 2 | Operand size select |
| operand | input | DATA_W | Value to shift or rotate |
| count | input | CNT_W | Raw shift count |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe, one clock after request |
| result | output | DATA_W | Shifted or rotated value |
| flag_cf | output | 1 | New carry flag |
| flag_of | output | 1 | New overflow flag |
| flag_sf | output | 1 | New sign flag |
| flag_zf | output | 1 | New zero flag |
| flag_pf | output | 1 | New parity flag |
| flag_we | output | 5 | Write enables {OF, SF, ZF, PF, CF} |

## Verification
The properties assume that `in_valid`, `op`, `size` and `count` are known values on every clock edge after reset, and that a request is judged only by the outputs on the following cycle. The stimulus drives every input from time zero, changes inputs only on the falling edge, and holds `in_valid` low between bursts. Directed cases aim at counts of 0, 1, the size, size+1 and values above 31. Random requests spread evenly over all operation codes, all four size codes and the whole count range, with junk in the upper operand bits.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam int SR_DATA_W = 32;
  localparam int SR_IDX_W  = $clog2(SR_DATA_W);

  typedef enum logic [2:0] {
    OP_ROL  = 3'd0,
    OP_ROR  = 3'd1,
    OP_RCL  = 3'd2,
    OP_RCR  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_SHL2 = 3'd6,
    OP_SAR  = 3'd7
  } shrot_op_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_32B = 2'd3
  } shrot_size_e;

  // flag_we / flag vector bit positions
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_ZF = 2;
  localparam int FL_SF = 3;
  localparam int FL_OF = 4;
  localparam int FL_N  = 5;

  function automatic logic [SR_IDX_W-1:0] top_index(input logic [1:0] sz);
    case (sz)
      SZ_8:    top_index = SR_IDX_W'(7);
      SZ_16:   top_index = SR_IDX_W'(15);
      default: top_index = SR_IDX_W'(SR_DATA_W - 1);
    endcase
  endfunction

  function automatic logic [SR_DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_8:    size_mask = SR_DATA_W'(8'hFF);
      SZ_16:   size_mask = SR_DATA_W'(16'hFFFF);
      default: size_mask = '1;
    endcase
  endfunction

endpackage

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int DATA_W = SR_DATA_W,
  parameter int STEP_W = 5
) (
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [STEP_W-1:0] steps,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry_out,
  output logic              orig_msb
);

  localparam int MAX_STEPS = (1 << STEP_W) - 1;

  logic [SR_IDX_W-1:0] msb;
  logic [DATA_W-1:0]   mask;
  logic [DATA_W-1:0]   v;
  logic                c;
  logic                bit_out;
  logic                sign;

  assign msb      = top_index(size);
  assign mask     = size_mask(size);
  assign orig_msb = operand[msb];

  // One single-bit step per iteration; steps beyond the count are bypassed.
  always_comb begin
    v       = operand & mask;
    c       = carry_in;
    sign    = v[msb];
    bit_out = 1'b0;
    for (int i = 0; i < MAX_STEPS; i++) begin
      if (i < int'(steps)) begin
        case (shrot_op_e'(op))
          OP_ROL: begin
            bit_out = v[msb];
            v       = (v << 1) & mask;
            v[0]    = bit_out;
            c       = bit_out;
          end
          OP_ROR: begin
            bit_out = v[0];
            v       = v >> 1;
            v[msb]  = bit_out;
            c       = bit_out;
          end
          OP_RCL: begin
            bit_out = v[msb];
            v       = (v << 1) & mask;
            v[0]    = c;
            c       = bit_out;
          end
          OP_RCR: begin
            bit_out = v[0];
            v       = v >> 1;
            v[msb]  = c;
            c       = bit_out;
          end
          OP_SHR: begin
            c = v[0];
            v = v >> 1;
          end
          OP_SAR: begin
            c      = v[0];
            v      = v >> 1;
            v[msb] = sign;
          end
          default: begin
            c = v[msb];
            v = (v << 1) & mask;
          end
        endcase
      end
    end
    res       = v;
    carry_out = c;
  end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int DATA_W = SR_DATA_W,
  parameter int STEP_W = 5
) (
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [STEP_W-1:0] steps,
  input  logic [DATA_W-1:0] res,
  input  logic              carry_out,
  input  logic              orig_msb,
  output logic [FL_N-1:0]   flags,
  output logic [FL_N-1:0]   we
);

  logic [SR_IDX_W-1:0] msb;
  logic [SR_IDX_W-1:0] msb2;
  logic                nonzero;
  logic                single;
  logic                is_shift;
  logic                ovf;
  logic [FL_N-1:0]     raw;

  assign msb      = top_index(size);
  assign msb2     = msb - SR_IDX_W'(1);
  assign nonzero  = (steps != '0);
  assign single   = (steps == STEP_W'(1));
  assign is_shift = op[2];

  always_comb begin
    case (shrot_op_e'(op))
      OP_ROR, OP_RCR: ovf = res[msb] ^ res[msb2];
      OP_SHR:         ovf = orig_msb;
      OP_SAR:         ovf = 1'b0;
      default:        ovf = carry_out ^ res[msb];
    endcase
  end

  always_comb begin
    raw        = '0;
    raw[FL_CF] = carry_out;
    raw[FL_OF] = ovf;
    raw[FL_SF] = res[msb];
    raw[FL_ZF] = (res == '0);
    raw[FL_PF] = ~^res[7:0];

    we         = '0;
    we[FL_CF]  = nonzero;
    we[FL_OF]  = single;
    we[FL_SF]  = nonzero & is_shift;
    we[FL_ZF]  = nonzero & is_shift;
    we[FL_PF]  = nonzero & is_shift;
  end

  assign flags = raw & we;

  always_comb begin
    if (!nonzero) begin
      AST_NO_WE_ON_ZERO: assert (we == '0); // R4
    end
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W   = SR_DATA_W,
  parameter int CNT_W    = 8,
  parameter int CNT_KEEP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_cf,
  output logic              flag_of,
  output logic              flag_sf,
  output logic              flag_zf,
  output logic              flag_pf,
  output logic [4:0]        flag_we
);

  logic [CNT_KEEP-1:0] steps;
  logic [DATA_W-1:0]   core_res;
  logic                core_cout;
  logic                core_msb;
  logic [FL_N-1:0]     nxt_flags;
  logic [FL_N-1:0]     nxt_we;
  logic [FL_N-1:0]     flags_q;
  logic                unused_count_hi;

  assign steps           = count[CNT_KEEP-1:0];
  assign unused_count_hi = ^count[CNT_W-1:CNT_KEEP];

  shrot_core #(.DATA_W(DATA_W), .STEP_W(CNT_KEEP)) u_core (
    .op        (op),
    .size      (size),
    .steps     (steps),
    .operand   (operand),
    .carry_in  (carry_in),
    .res       (core_res),
    .carry_out (core_cout),
    .orig_msb  (core_msb)
  );

  shrot_flags #(.DATA_W(DATA_W), .STEP_W(CNT_KEEP)) u_flags (
    .op        (op),
    .size      (size),
    .steps     (steps),
    .res       (core_res),
    .carry_out (core_cout),
    .orig_msb  (core_msb),
    .flags     (nxt_flags),
    .we        (nxt_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_q   <= '0;
      flag_we   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= core_res;
        flags_q <= nxt_flags;
        flag_we <= nxt_we;
      end
    end
  end

  assign flag_cf = flags_q[FL_CF];
  assign flag_of = flags_q[FL_OF];
  assign flag_sf = flags_q[FL_SF];
  assign flag_zf = flags_q[FL_ZF];
  assign flag_pf = flags_q[FL_PF];

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == SZ_8) |=> (result[DATA_W-1:8] == '0)); // R2
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && steps == '0) |=>
      (flag_we == '0 && result == ($past(operand) & size_mask($past(size))))); // R4
  AST_OF_ONLY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && steps > CNT_KEEP'(1)) |=> (!flag_we[FL_OF] && !flag_of)); // R9
  AST_SAR_OF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SAR && steps == CNT_KEEP'(1)) |=> (flag_we[FL_OF] && !flag_of)); // R8
  AST_SAR_KEEPS_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SAR && size == SZ_32) |=>
      (result[DATA_W-1] == $past(operand[DATA_W-1]))); // R10
  AST_ROTATE_NO_SZP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op[2]) |=> (flag_we[FL_SF:FL_PF] == '0)); // R12

endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  fv;
    logic [4:0]  we;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] operand = '0;
  logic [7:0]  count = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_cf, flag_of, flag_sf, flag_zf, flag_pf;
  logic [4:0]  flag_we;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .operand(operand), .count(count), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .flag_cf(flag_cf),
    .flag_of(flag_of), .flag_sf(flag_sf), .flag_zf(flag_zf),
    .flag_pf(flag_pf), .flag_we(flag_we)
  );

  // Reference model built from rotation identities and wide shifts.
  function automatic exp_t model(input logic [2:0] o, input logic [1:0] sz,
                                 input logic [31:0] val, input logic [7:0] cnt_raw,
                                 input logic ci, input string tag);
    exp_t        e;
    int          w, n, k, w1;
    logic [63:0] m, vm, r, rr, sx, x;
    logic        cf, of;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    n  = int'(cnt_raw) % 32;
    m  = (64'd1 << w) - 64'd1;
    vm = {32'd0, val} & m;
    cf = 1'b0;
    x  = vm;
    e.tag = tag;
    e.fv  = '0;
    e.we  = '0;
    if (n == 0) begin
      e.res = vm[31:0];
      return e;
    end
    case (o)
      3'd0, 3'd1: begin
        k = n % w;
        if (k == 0) x = vm;
        else if (o == 3'd0) x = ((vm << k) | (vm >> (w - k))) & m;
        else x = ((vm >> k) | (vm << (w - k))) & m;
        cf = (o == 3'd0) ? x[0] : x[w-1];
      end
      3'd2, 3'd3: begin
        w1 = w + 1;
        r  = vm | ({63'd0, ci} << w);
        k  = n % w1;
        if (k == 0) rr = r;
        else if (o == 3'd2) rr = ((r << k) | (r >> (w1 - k))) & ((64'd1 << w1) - 64'd1);
        else rr = ((r >> k) | (r << (w1 - k))) & ((64'd1 << w1) - 64'd1);
        x  = rr & m;
        cf = rr[w];
      end
      3'd5: begin
        x  = vm >> n;
        cf = vm[n-1];
      end
      3'd7: begin
        sx = vm[w-1] ? (vm | ~m) : vm;
        x  = 64'($signed(sx) >>> n) & m;
        cf = sx[n-1];
      end
      default: begin
        r  = vm << n;
        x  = r & m;
        cf = r[w];
      end
    endcase
    case (o)
      3'd1, 3'd3: of = x[w-1] ^ x[w-2];
      3'd5:       of = vm[w-1];
      3'd7:       of = 1'b0;
      default:    of = cf ^ x[w-1];
    endcase
    e.res   = x[31:0];
    e.we[0] = 1'b1;
    e.fv[0] = cf;
    if (n == 1) begin
      e.we[4] = 1'b1;
      e.fv[4] = of;
    end
    if (o[2]) begin
      e.we[3:1] = 3'b111;
      e.fv[3]   = x[w-1];
      e.fv[2]   = (x == 64'd0);
      e.fv[1]   = ~^x[7:0];
    end
    return e;
  endfunction

  task automatic send(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] val,
                      input logic [7:0] c, input logic ci, input string tag);
    @(negedge clk);
    op       = o;
    size     = sz;
    operand  = val;
    count    = c;
    carry_in = ci;
    in_valid = 1'b1;
    sb.push_back(model(o, sz, val, c, ci, tag));
  endtask

  // Monitor: compares each produced result with the oldest expected item.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_run++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R1: unexpected out_valid, actual 1 expected 0");
      end else begin
        exp_t e;
        logic [4:0] fa;
        e  = sb.pop_front();
        fa = {flag_of, flag_sf, flag_zf, flag_pf, flag_cf};
        if (result !== e.res || fa !== e.fv || flag_we !== e.we) begin
          n_fail++;
          $display("FAIL %s: actual res=%h flags=%b we=%b expected res=%h flags=%b we=%b",
                   e.tag, result, fa, flag_we, e.res, e.fv, e.we);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state while reset is held
    n_run++;
    if (out_valid !== 1'b0 || result !== '0 || flag_we !== '0 ||
        {flag_of, flag_sf, flag_zf, flag_pf, flag_cf} !== '0) begin
      n_fail++;
      $display("FAIL R13: actual valid=%b res=%h we=%b expected 0 0 0", out_valid, result, flag_we);
    end
    rst = 1'b0;
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || result !== '0 || flag_we !== '0) begin
      n_fail++;
      $display("FAIL R13: after release actual valid=%b res=%h expected 0 0", out_valid, result);
    end

    send(3'd0, 2'd0, 32'h81,       8'd1,  1'b0, "R7 rol8 c1");
    send(3'd1, 2'd1, 32'h0001,     8'd1,  1'b0, "R7 ror16 c1");
    send(3'd2, 2'd0, 32'h80,       8'd1,  1'b0, "R5 rcl8 c1");
    send(3'd3, 2'd0, 32'h5A,       8'd9,  1'b1, "R5 rcr8 ring9");
    send(3'd2, 2'd1, 32'h8001,     8'd17, 1'b0, "R5 rcl16 ring17");
    send(3'd2, 2'd2, 32'hC000_0001, 8'd31, 1'b1, "R5 rcl32 c31");
    send(3'd3, 2'd0, 32'h01,       8'd1,  1'b1, "R7 rcr8 c1");
    send(3'd4, 2'd0, 32'h81,       8'd40, 1'b0, "R3 shl count40");
    send(3'd4, 2'd1, 32'h1234,     8'd32, 1'b1, "R4 count32 quiet");
    send(3'd0, 2'd0, 32'hFFFF_FF3C, 8'd0, 1'b1, "R4 zero count");
    send(3'd5, 2'd0, 32'h80,       8'd1,  1'b0, "R8 shr8 c1");
    send(3'd7, 2'd1, 32'h8000,     8'd1,  1'b0, "R8 sar16 c1");
    send(3'd7, 2'd0, 32'h80,       8'd7,  1'b0, "R10 sar8 c7");
    send(3'd7, 2'd0, 32'h90,       8'd20, 1'b0, "R10 sar8 c20");
    send(3'd7, 2'd2, 32'h8000_0000, 8'd31, 1'b0, "R10 sar32 c31");
    send(3'd4, 2'd0, 32'h71,       8'd3,  1'b0, "R9 shl8 c3");
    send(3'd0, 2'd1, 32'h8000,     8'd5,  1'b1, "R12 rol16");
    send(3'd4, 2'd0, 32'h80,       8'd1,  1'b0, "R11 shl zero result");
    send(3'd5, 2'd1, 32'h0F06,     8'd1,  1'b0, "R11 parity");
    send(3'd5, 2'd2, 32'h0000_0010, 8'd5, 1'b0, "R6 shr32 last out");
    send(3'd1, 2'd2, 32'h0000_0001, 8'd32, 1'b0, "R3 ror32 count32");
    send(3'd0, 2'd3, 32'h8000_0001, 8'd4, 1'b0, "R2 size code3");
    send(3'd5, 2'd0, 32'hABCD_EF0F, 8'd2, 1'b0, "R2 narrow junk");
    send(3'd6, 2'd1, 32'h4001,     8'd1,  1'b0, "R1 code6 alias");
    send(3'd4, 2'd0, 32'hFF,       8'd9,  1'b1, "R6 shl8 past width");

    for (int i = 0; i < 400; i++) begin
      send(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom(),
           8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), "R1 random");
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    n_run++;
    if (sb.size() != 0 || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual pending=%0d valid=%b expected 0 0", sb.size(), out_valid);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule